// File: doc/BRIEF.md
# Banked Address Translation Unit

This block sits between the requesters of a small system bus and the external memory bus. It maps 24-bit logical addresses that fall inside two fixed 2 MB windows (called Y and Z) onto one of eight 2 MB banks of the physical address space. Every other address is forwarded without change. Each window owns four bank registers, one for each kind of access: CPU data read, CPU data write, display-controller DMA read and instruction fetch. A sideband kind code sent with every access picks the register that applies. So, for example, the CPU can fill a frame buffer through one bank while the display engine scans out another.

Chip selects are decoded from the logical address and never from the translated one. The memory that answers is therefore fixed by the window, while the bank registers only choose where inside the physical space the access lands. A write-only configuration port loads the bank registers. A window's fetch-bank register is locked while code is running from inside that window, so software cannot pull its own code out from under itself.

Each access is presented for one cycle and its result appears on registered outputs one clock later.

Top module: `banked_xlat`

## Requirements
- R1: While rst_n is low at a clock edge, all eight bank registers clear to 0x0000, phys_valid_o goes to 0, and phys_addr_o and cs_o go to 0. The fetch-tracking state becomes "outside both windows".
- R2: The bank register used for an access is chosen from the accessed window and acc_kind_i. The kind codes are 0 for CPU read, 1 for CPU write, 2 for DMA read and 3 for instruction fetch. Registers of other kinds have no effect.
- R3: cfg_sel_i addresses a register as follows: bit 2 is the window (0 for Y, 1 for Z) and bits 1:0 are the kind code. A write takes effect at the clock edge that samples cfg_we_i. An access in that same cycle still uses the old value.
- R4: When the selected register has bit 15 set, the physical address is register bits 2:0 followed by logical bits 20:0. With 0x8001, an access to 0x400000 becomes 0x200000.
- R5: When the selected register has bit 15 clear, or the address is outside both windows, phys_addr_o equals the logical address.
- R6: Window Y covers logical 0x400000 to 0x5FFFFF and window Z covers 0x800000 to 0x9FFFFF. The addresses 0x3FFFFF, 0x600000 and 0xA00000 are outside both windows.
- R7: cs_o is one-hot and decoded from the logical address: bit 0 for window Y, bit 1 for window Z, bit 2 for everything else.
- R8: A write to a window's fetch register (kind 3) is ignored while the most recent fetch lay inside that same window. Writes to the other window and to the other kinds are still accepted.
- R9: The fetch-tracking state is updated by every fetch. A fetch outside both windows, or inside the other window, unlocks the window's fetch register again.
- R10: The outputs are registered. An access sampled at one edge shows on phys_addr_o, cs_o and phys_valid_o after that edge. In a cycle without an access, phys_valid_o is 0 and phys_addr_o and cs_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_addr_i | input | 24 | Logical address of the access |
| acc_kind_i | input | 2 | Access kind: 0 read, 1 write, 2 DMA read, 3 fetch |
| cfg_we_i | input | 1 | Bank register write strobe |
| cfg_sel_i | input | 3 | Register select: bit 2 window, bits 1:0 kind |
| cfg_data_i | input | 16 | Register value: bit 15 enable, bits 2:0 bank |
| phys_addr_o | output | 24 | Translated physical address |
| cs_o | output | 3 | One-hot chip select: Y, Z, other |
| phys_valid_o | output | 1 | phys_addr_o and cs_o belong to an access of the previous cycle |

## Verification
Several behaviours are checked by the assertions on every cycle:
- the one-cycle relation between an access and phys_valid_o;
- offset bits that pass through unchanged;
- untranslated forwarding outside the windows;
- one-hot chip selects that follow the logical window;
- each accepted register write landing one edge later;
- a stable fetch register whenever a write to it is locked.

Other behaviours can only be shown by the bench scenarios. These are the choice of the correct register for each access kind, the bank arithmetic at the window edges, and the order-dependent lock sequence (lock, write to the other window, move of execution, unlock by a fetch outside both windows). The same holds for the same-cycle collision of a register write with an access, and for clearing by a mid-run reset.

// File: rtl/bx_pkg.sv
// Shared definitions for the banked address translation unit.
// Assumes exactly four access kinds; the window count is a package constant.
package bx_pkg;
    typedef enum logic [1:0] {
        KIND_RD    = 2'd0,
        KIND_WR    = 2'd1,
        KIND_DMA   = 2'd2,
        KIND_FETCH = 2'd3
    } acc_kind_e;

    localparam int NKIND = 4;
    localparam int NWIN  = 2;
endpackage

// File: rtl/bx_win_decode.sv
// Window hit and chip-select decode from the logical address.
// Assumes every window is aligned to 2**OFF_W and the window tags differ.
module bx_win_decode #(
    parameter int                          ADDR_W   = 24,
    parameter int                          OFF_W    = 21,
    parameter int                          NWIN     = 2,
    parameter logic [NWIN*(ADDR_W-OFF_W)-1:0] WIN_TAGS = 6'b100_010
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NWIN-1:0]   hit_o,
    output logic [NWIN:0]     cs_o
);
    localparam int TAG_W = ADDR_W - OFF_W;

    for (genvar w = 0; w < NWIN; w++) begin : g_hit
        // compare the upper address bits against this window's tag
        assign hit_o[w] = (addr_i[ADDR_W-1 -: TAG_W] == WIN_TAGS[w*TAG_W +: TAG_W]);
    end

    // one chip select per window plus a default select for everything else
    assign cs_o = {~|hit_o, hit_o};
endmodule

// File: rtl/bx_bank_regs.sv
// Bank register file: one register per window and access kind, plus the
// fetch-lock state that remembers which window the last fetch came from.
// Assumes the select layout {window, kind} with kind in the low two bits.
module bx_bank_regs
    import bx_pkg::*;
#(
    parameter int NWIN  = 2,
    parameter int REG_W = 16,
    parameter int SEL_W = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we_i,
    input  logic [SEL_W-1:0]                   cfg_sel_i,
    input  logic [REG_W-1:0]                   cfg_data_i,
    input  logic                               fetch_i,
    input  logic [NWIN-1:0]                    fetch_hit_i,
    output logic [NWIN-1:0][NKIND-1:0][REG_W-1:0] bank_o,
    output logic [NWIN-1:0]                    exec_hit_o
);
    logic [NWIN-1:0] exec_q;

    // track the window that the most recent instruction fetch came from
    always_ff @(posedge clk) begin
        if (!rst_n)       exec_q <= '0;
        else if (fetch_i) exec_q <= fetch_hit_i;
    end

    assign exec_hit_o = exec_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        for (genvar k = 0; k < NKIND; k++) begin : g_kind
            logic             sel_me;
            logic             lock;
            logic [REG_W-1:0] q;

            assign sel_me = cfg_we_i && (cfg_sel_i == SEL_W'(w*NKIND + k));

            if (k == NKIND-1) begin : g_fetch_lock
                assign lock = exec_q[w];
            end else begin : g_no_lock
                assign lock = 1'b0;
            end

            // load the register unless the fetch lock of its window is held
            always_ff @(posedge clk) begin
                if (!rst_n)               q <= '0;
                else if (sel_me && !lock) q <= cfg_data_i;
            end

            assign bank_o[w][k] = q;
        end
    end
endmodule

// File: rtl/bx_remap.sv
// Combinational remap: replaces the upper address bits by the bank number
// of the selected register when the address hits an enabled window.
// Assumes at most one window hits at a time.
module bx_remap
    import bx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 21,
    parameter int NWIN   = 2,
    parameter int REG_W  = 16,
    parameter int EN_BIT = 15
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [1:0]                         kind_i,
    input  logic [NWIN-1:0]                    hit_i,
    input  logic [NWIN-1:0][NKIND-1:0][REG_W-1:0] bank_i,
    output logic [ADDR_W-1:0]                  phys_o
);
    localparam int BANK_W = ADDR_W - OFF_W;

    logic unused_bank_bits;
    assign unused_bank_bits = ^bank_i;

    // choose the bank of the hit window, else forward the address as is
    always_comb begin
        phys_o = addr_i;
        for (int w = 0; w < NWIN; w++) begin
            if (hit_i[w] && bank_i[w][kind_i][EN_BIT]) begin
                phys_o = {bank_i[w][kind_i][BANK_W-1:0], addr_i[OFF_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/banked_xlat.sv
// Top of the banked address translation unit. Decodes windows, selects the
// bank register by access kind, remaps, and registers the bus outputs.
// Assumes one access per cycle and that cs_o follows the logical address.
module banked_xlat
    import bx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 21,
    parameter int REG_W  = 16,
    parameter int EN_BIT = 15,
    parameter logic [ADDR_W-OFF_W-1:0] Y_TAG = 3'b010,
    parameter logic [ADDR_W-OFF_W-1:0] Z_TAG = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [1:0]        acc_kind_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [REG_W-1:0]  cfg_data_i,
    output logic [ADDR_W-1:0] phys_addr_o,
    output logic [NWIN:0]     cs_o,
    output logic              phys_valid_o
);
    localparam int SEL_W = $clog2(NWIN) + 2;

    logic [NWIN-1:0]                     hit;
    logic [NWIN:0]                       cs_d;
    logic [NWIN-1:0]                     exec_hit;
    logic [NWIN-1:0][NKIND-1:0][REG_W-1:0] bank_q;
    logic [ADDR_W-1:0]                   phys_d;
    logic                                is_fetch;

    assign is_fetch = acc_valid_i && (acc_kind_e'(acc_kind_i) == KIND_FETCH);

    bx_win_decode #(
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .NWIN    (NWIN),
        .WIN_TAGS({Z_TAG, Y_TAG})
    ) dec_i (
        .addr_i(acc_addr_i),
        .hit_o (hit),
        .cs_o  (cs_d)
    );

    bx_bank_regs #(
        .NWIN (NWIN),
        .REG_W(REG_W),
        .SEL_W(SEL_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_data_i (cfg_data_i),
        .fetch_i    (is_fetch),
        .fetch_hit_i(hit),
        .bank_o     (bank_q),
        .exec_hit_o (exec_hit)
    );

    bx_remap #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W),
        .NWIN  (NWIN),
        .REG_W (REG_W),
        .EN_BIT(EN_BIT)
    ) map_i (
        .addr_i(acc_addr_i),
        .kind_i(acc_kind_i),
        .hit_i (hit),
        .bank_i(bank_q),
        .phys_o(phys_d)
    );

    // capture the translated address and selects once per access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr_o  <= '0;
            cs_o         <= '0;
            phys_valid_o <= 1'b0;
        end else begin
            phys_valid_o <= acc_valid_i;
            if (acc_valid_i) begin
                phys_addr_o <= phys_d;
                cs_o        <= cs_d;
            end
        end
    end
endmodule

// File: rtl/banked_xlat_chk.sv
// Property checker for banked_xlat, attached by bind. Observes ports and the
// register file state; drives nothing.
module banked_xlat_chk
    import bx_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OFF_W  = 21,
    parameter int REG_W  = 16,
    parameter logic [ADDR_W-OFF_W-1:0] Y_TAG = 3'b010,
    parameter logic [ADDR_W-OFF_W-1:0] Z_TAG = 3'b100
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               acc_valid_i,
    input logic [ADDR_W-1:0]                  acc_addr_i,
    input logic                               cfg_we_i,
    input logic [2:0]                         cfg_sel_i,
    input logic [REG_W-1:0]                   cfg_data_i,
    input logic [ADDR_W-1:0]                  phys_addr_o,
    input logic [NWIN:0]                      cs_o,
    input logic                               phys_valid_o,
    input logic [NWIN-1:0]                    exec_hit,
    input logic [NWIN-1:0][NKIND-1:0][REG_W-1:0] bank_q
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] tag;
    logic             in_y;
    logic             in_z;
    logic             sel_win;
    logic [1:0]       sel_kind;
    logic             locked_wr;

    assign tag       = acc_addr_i[ADDR_W-1 -: TAG_W];
    assign in_y      = (tag == Y_TAG);
    assign in_z      = (tag == Z_TAG);
    assign sel_win   = cfg_sel_i[2];
    assign sel_kind  = cfg_sel_i[1:0];
    assign locked_wr = (sel_kind == 2'd3) && exec_hit[sel_win];

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> phys_valid_o);
    a_r10_idle_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_i |=> !phys_valid_o);
    a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> phys_addr_o[OFF_W-1:0] == $past(acc_addr_i[OFF_W-1:0]));
    a_r5_outside_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !in_y && !in_z) |=> phys_addr_o == $past(acc_addr_i));
    a_r7_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        phys_valid_o |-> $countones(cs_o) == 1);
    a_r7_cs_y_logical: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> cs_o[0] == $past(in_y));
    a_r7_cs_z_logical: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_i |=> cs_o[1] == $past(in_z));
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !locked_wr) |=>
            bank_q[$past(sel_win)][$past(sel_kind)] == $past(cfg_data_i));
    a_r8_y_fetch_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i == 3'b011 && exec_hit[0]) |=> $stable(bank_q[0][3]));
    a_r8_z_fetch_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i == 3'b111 && exec_hit[1]) |=> $stable(bank_q[1][3]));
endmodule

bind banked_xlat banked_xlat_chk #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .REG_W (REG_W),
    .Y_TAG (Y_TAG),
    .Z_TAG (Z_TAG)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid_i (acc_valid_i),
    .acc_addr_i  (acc_addr_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_data_i  (cfg_data_i),
    .phys_addr_o (phys_addr_o),
    .cs_o        (cs_o),
    .phys_valid_o(phys_valid_o),
    .exec_hit    (exec_hit),
    .bank_q      (bank_q)
);

// File: tb/banked_xlat_tb_top.sv
// Self-checking bench for banked_xlat: a vector table walked in order,
// followed by directed tests for same-cycle writes, idle cycles and reset.
module banked_xlat_tb_top;
    typedef struct packed {
        logic        is_acc;
        logic [2:0]  sel;
        logic [23:0] addr;
        logic [15:0] data;
        logic [23:0] exp_phys;
        logic [2:0]  exp_cs;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t wr(input logic [2:0] s, input logic [15:0] d, input logic [3:0] r);
        wr = '{1'b0, s, 24'h0, d, 24'h0, 3'b0, r};
    endfunction

    function automatic vec_t ac(input logic [23:0] a, input logic [1:0] k,
                                input logic [23:0] p, input logic [2:0] c, input logic [3:0] r);
        ac = '{1'b1, {1'b0, k}, a, 16'h0, p, c, r};
    endfunction

    // sel: bit2 window (0 Y, 1 Z), bits1:0 kind; kind 0 rd, 1 wr, 2 dma, 3 fetch
    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        ac(24'h400123, 2'd0, 24'h400123, 3'b001, 4'd1), // R1 cleared regs forward
        wr(3'b001, 16'h8001, 4'd3),                     // R3 Y write bank 1
        ac(24'h400000, 2'd1, 24'h200000, 3'b001, 4'd4), // R4 write remapped
        ac(24'h400000, 2'd0, 24'h400000, 3'b001, 4'd2), // R2 read reg still off
        wr(3'b100, 16'h8000, 4'd3),                     // Z read bank 0
        ac(24'h800000, 2'd0, 24'h000000, 3'b010, 4'd7), // R7 cs from logical
        wr(3'b010, 16'h8001, 4'd3),                     // Y dma bank 1
        ac(24'h400000, 2'd2, 24'h200000, 3'b001, 4'd2), // R2 dma register
        ac(24'h123456, 2'd0, 24'h123456, 3'b100, 4'd5), // R5 outside windows
        wr(3'b000, 16'h0005, 4'd3),                     // Y read, enable clear
        ac(24'h4ABCDE, 2'd0, 24'h4ABCDE, 3'b001, 4'd5), // R5 disabled forwards
        wr(3'b011, 16'h8000, 4'd3),                     // Y fetch bank 0
        ac(24'h400010, 2'd3, 24'h000010, 3'b001, 4'd4), // R4 fetch offset kept
        wr(3'b011, 16'h8003, 4'd8),                     // R8 locked, ignored
        ac(24'h400010, 2'd3, 24'h000010, 3'b001, 4'd8), // R8 bank unchanged
        wr(3'b011 | 3'b100, 16'h8002, 4'd8),            // R8 other window accepted
        ac(24'h800004, 2'd3, 24'h400004, 3'b010, 4'd8), // R8 Z fetch bank 2
        wr(3'b011, 16'h8003, 4'd9),                     // R9 unlocked now
        ac(24'h5FFFFF, 2'd3, 24'h7FFFFF, 3'b001, 4'd6), // R6 top of Y
        ac(24'h600000, 2'd0, 24'h600000, 3'b100, 4'd6), // R6 above Y
        ac(24'h3FFFFF, 2'd0, 24'h3FFFFF, 3'b100, 4'd6), // R6 below Y
        ac(24'h9FFFFF, 2'd0, 24'h1FFFFF, 3'b010, 4'd6), // R6 top of Z
        ac(24'hA00000, 2'd0, 24'hA00000, 3'b100, 4'd6), // R6 above Z
        ac(24'h001000, 2'd3, 24'h001000, 3'b100, 4'd9), // R9 fetch outside
        wr(3'b011, 16'h8001, 4'd9),                     // R9 accepted again
        ac(24'h400000, 2'd3, 24'h200000, 3'b001, 4'd9)  // R9 new fetch bank
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic [23:0] phys_addr;
    logic [2:0]  cs;
    logic        phys_valid;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    banked_xlat dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid),
        .acc_addr_i  (acc_addr),
        .acc_kind_i  (acc_kind),
        .cfg_we_i    (cfg_we),
        .cfg_sel_i   (cfg_sel),
        .cfg_data_i  (cfg_data),
        .phys_addr_o (phys_addr),
        .cs_o        (cs),
        .phys_valid_o(phys_valid)
    );

    task automatic check_out(input int req, input logic v, input logic [23:0] p, input logic [2:0] c);
        checks++;
        if (phys_valid !== v || phys_addr !== p || cs !== c) begin
            failures++;
            $display("FAIL R%0d: valid=%0b phys=%06h cs=%03b expected valid=%0b phys=%06h cs=%03b",
                     req, phys_valid, phys_addr, cs, v, p, c);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        if (v.is_acc) begin
            acc_valid = 1'b1; acc_addr = v.addr; acc_kind = v.sel[1:0];
        end else begin
            cfg_we = 1'b1; cfg_sel = v.sel; cfg_data = v.data;
        end
        @(negedge clk);
        acc_valid = 1'b0;
        cfg_we = 1'b0;
        if (v.is_acc) check_out(int'(v.req), 1'b1, v.exp_phys, v.exp_cs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_out(1, 1'b0, 24'h0, 3'b000);          // R1 reset state
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // R3: write and access in one cycle use the old bank (1), then bank 3
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'b001; cfg_data = 16'h8003;
        acc_valid = 1'b1; acc_addr = 24'h400000; acc_kind = 2'd1;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        check_out(3, 1'b1, 24'h200000, 3'b001);
        apply(ac(24'h400000, 2'd1, 24'h600000, 3'b001, 4'd3));

        // R10: idle cycle drops valid and holds address and selects
        @(negedge clk);
        check_out(10, 1'b0, 24'h600000, 3'b001);

        // R1: mid-run reset clears outputs and registers
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_out(1, 1'b0, 24'h0, 3'b000);
        rst_n = 1'b1;
        apply(ac(24'h400000, 2'd1, 24'h400000, 3'b001, 4'd1));
        apply(ac(24'h400000, 2'd3, 24'h400000, 3'b001, 4'd1));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule